// File: doc/BRIEF.md
# Sine Capture Fault Pre-Screener

This block sits beside an ADC capture path while a sine stimulus drives the converter input. Every accepted sample is compared with the one accepted just before it. The block keeps a count of how many step magnitudes in a row look impossible for a clean sinusoid. A step is impossible when it is exactly zero (a stuck output) or when it is at least twice the largest per-sample step the stimulus can produce. When that count reaches a programmed run length, the block latches an abort. The capture controller uses the abort to give up the remaining capture and skip the later test steps.

Software works out the largest legal step from the stimulus amplitude, the input frequency and the sampling rate, and writes it to `max_step_i`. It also writes the run length to `run_len_i`. Both must be held stable while a capture is running. A `start_i` pulse arms the block. Samples then arrive on a valid/ready stream that carries an end-of-capture marker.

The stream follows these rules. A sample is taken only in a cycle where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only while the block is armed and has reached neither an abort nor a done result. While `s_ready_o` is low, the sender must hold its sample or drop it. A sample presented while ready is low has no effect. The block never stalls an armed capture, so ready does not drop for back-pressure while the block is armed.

Top module: `sine_prescreen`

## Requirements
- R1: After reset, `abort_o`, `done_o` and `s_ready_o` are all 0.
- R2: A `start_i` pulse (with `clear_i` low) raises `s_ready_o` from the next cycle and clears `abort_o`, `done_o`, the consecutive-step count and the stored previous sample, even in the middle of a capture.
- R3: The first sample accepted after a start produces no step and leaves the consecutive-step count unchanged.
- R4: A step whose magnitude is exactly 0 counts as abnormal.
- R5: A step counts as abnormal when its magnitude is at least 2×`max_step_i`. A nonzero step below 2×`max_step_i` is normal. For example, with `max_step_i`=100 a step of 200 is abnormal and a step of 199 is normal.
- R6: `abort_o` rises in the cycle after the sample that completes `run_len_i` consecutive abnormal steps is accepted. A normal step resets the consecutive-step count to 0.
- R7: Once `abort_o` is high, it stays high and `s_ready_o` stays low until a start or clear pulse. Samples presented during this time are ignored, and `done_o` stays 0.
- R8: If a sample accepted with `s_last_i`=1 does not trigger an abort, `done_o` rises in the next cycle and `s_ready_o` falls. If that sample completes the abnormal run, `abort_o` rises and `done_o` stays 0.
- R9: A `clear_i` pulse returns the block to idle, with all three outputs at 0. Clear takes precedence over start. A sample presented while idle is ignored.
- R10: A `run_len_i` of 0 behaves as a run length of 1.
- R11: Steps are formed one bit wider than the sample. The step from -2048 to 2047 has magnitude 4095 (12-bit samples) and is not wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm pulse; clears all results |
| clear_i | input | 1 | Disarm pulse; returns to idle |
| max_step_i | input | SAMPLE_W | Largest legal per-sample step magnitude, unsigned |
| run_len_i | input | RUN_W | Consecutive abnormal steps that declare a fault |
| s_valid_i | input | 1 | Sample valid |
| s_ready_o | output | 1 | Sample accepted when high together with valid |
| s_data_i | input | SAMPLE_W | Signed two's-complement sample |
| s_last_i | input | 1 | Marks the final sample of the capture |
| abort_o | output | 1 | Latched fault; request to abandon the capture |
| done_o | output | 1 | Capture ended without a fault |

## Verification
Repeated identical samples show whether the first sample after a start is kept out of the count. They also show that zero steps are counted, because the abort must appear on exactly the fourth sample of a run of three. Ramps that alternate steps of exactly twice the limit with steps one below it confirm the boundary of the threshold and the reset of the count on a normal step. A slow ramp ending with the last marker, and a stuck run ending on the last sample, separate done from abort. Full-scale swings between the two extreme codes expose a step computed at the sample width, and restarts during a run show that a start clears the count.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_ABORT = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;
endpackage

// File: rtl/ss_delta.sv
module ss_delta #(
  parameter int SAMPLE_W = 12,
  localparam int MAG_W = SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  input  logic                       take_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic                       diff_vld_o,
  output logic        [MAG_W-1:0]    mag_o
);
  logic signed [SAMPLE_W-1:0] prev_q;
  logic                       have_q;
  logic signed [MAG_W-1:0]    diff;

  always_comb begin
    diff  = {sample_i[SAMPLE_W-1], sample_i} - {prev_q[SAMPLE_W-1], prev_q};
    mag_o = diff[MAG_W-1] ? MAG_W'(-diff) : MAG_W'(diff);
  end

  assign diff_vld_o = have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (restart_i) begin
      have_q <= 1'b0;
    end else if (take_i) begin
      prev_q <= sample_i;
      have_q <= 1'b1;
    end
  end

  // R3
  prev_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !restart_i) |=> (have_q && prev_q == $past(sample_i)));

  // R11
  mag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |-> (mag_o <= MAG_W'((1 << SAMPLE_W) - 1)));
endmodule

// File: rtl/ss_classify.sv
module ss_classify #(
  parameter int SAMPLE_W = 12,
  localparam int MAG_W = SAMPLE_W + 1
) (
  input  logic [MAG_W-1:0]    mag_i,
  input  logic [SAMPLE_W-1:0] max_step_i,
  output logic                abnormal_o
);
  logic [MAG_W-1:0] limit2;

  assign limit2     = {max_step_i, 1'b0};
  assign abnormal_o = (mag_i == '0) || (mag_i >= limit2);
endmodule

// File: rtl/ss_runctl.sv
module ss_runctl
  import ss_pkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             diff_vld_i,
  input  logic             abnormal_i,
  input  logic             last_i,
  input  logic [RUN_W-1:0] run_len_i,
  output phase_e           phase_o
);
  phase_e           phase_q;
  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W-1:0] limit;
  logic             hit;

  assign limit = (run_len_i == '0) ? RUN_W'(1) : run_len_i;
  assign hit   = diff_vld_i && abnormal_i &&
                 (({1'b0, cnt_q} + (RUN_W+1)'(1)) >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (clear_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else if (take_i) begin
      if (diff_vld_i) begin
        cnt_q <= abnormal_i ? cnt_q + RUN_W'(1) : '0;
      end
      if (hit) begin
        phase_q <= PH_ABORT;
      end else if (last_i) begin
        phase_q <= PH_DONE;
      end
    end
  end

  assign phase_o = phase_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (cnt_q < limit));

  // R7
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ABORT && !start_i && !clear_i) |=> (phase_q == PH_ABORT));

  // R8
  done_needs_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_q == PH_DONE) |-> $past(take_i && last_i));
endmodule

// File: rtl/sine_prescreen.sv
module sine_prescreen
  import ss_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RUN_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       clear_i,
  input  logic        [SAMPLE_W-1:0] max_step_i,
  input  logic        [RUN_W-1:0]    run_len_i,
  input  logic                       s_valid_i,
  output logic                       s_ready_o,
  input  logic signed [SAMPLE_W-1:0] s_data_i,
  input  logic                       s_last_i,
  output logic                       abort_o,
  output logic                       done_o
);
  localparam int MAG_W = SAMPLE_W + 1;

  phase_e           phase;
  logic             take;
  logic             diff_vld;
  logic [MAG_W-1:0] mag;
  logic             abnormal;

  assign s_ready_o = (phase == PH_RUN);
  assign take      = s_valid_i && s_ready_o;
  assign abort_o   = (phase == PH_ABORT);
  assign done_o    = (phase == PH_DONE);

  ss_delta #(.SAMPLE_W(SAMPLE_W)) u_delta (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (start_i | clear_i),
    .take_i     (take),
    .sample_i   (s_data_i),
    .diff_vld_o (diff_vld),
    .mag_o      (mag)
  );

  ss_classify #(.SAMPLE_W(SAMPLE_W)) u_class (
    .mag_i      (mag),
    .max_step_i (max_step_i),
    .abnormal_o (abnormal)
  );

  ss_runctl #(.RUN_W(RUN_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .take_i     (take),
    .diff_vld_i (diff_vld),
    .abnormal_i (abnormal),
    .last_i     (s_last_i),
    .run_len_i  (run_len_i),
    .phase_o    (phase)
  );

  // R7
  ready_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !s_ready_o);

  // R8
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && done_o));

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!s_ready_o && !abort_o && !done_o));
endmodule

// File: tb/sim_sine_prescreen.sv
module sim_sine_prescreen;
  localparam int SW = 12;
  localparam int RW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start_i = 1'b0;
  logic                 clear_i = 1'b0;
  logic        [SW-1:0] max_step_i = '0;
  logic        [RW-1:0] run_len_i = '0;
  logic                 s_valid_i = 1'b0;
  logic                 s_ready_o;
  logic signed [SW-1:0] s_data_i = '0;
  logic                 s_last_i = 1'b0;
  logic                 abort_o;
  logic                 done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit m_active = 0, m_abort = 0, m_done = 0, m_have = 0;
  int m_prev = 0, m_run = 0;

  sine_prescreen #(.SAMPLE_W(SW), .RUN_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clear_i(clear_i),
    .max_step_i(max_step_i), .run_len_i(run_len_i),
    .s_valid_i(s_valid_i), .s_ready_o(s_ready_o), .s_data_i(s_data_i),
    .s_last_i(s_last_i), .abort_o(abort_o), .done_o(done_o)
  );

  always #5 clk = ~clk;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      summary();
    end
  end

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n || clear_i) begin
      m_active = 0; m_abort = 0; m_done = 0; m_have = 0; m_run = 0;
    end else if (start_i) begin
      m_active = 1; m_abort = 0; m_done = 0; m_have = 0; m_run = 0;
    end else if (s_valid_i && m_active && !m_abort && !m_done) begin
      int x;
      int lim;
      x = s_data_i;
      lim = (run_len_i == 0) ? 1 : int'(run_len_i);
      if (m_have) begin
        int d;
        d = (x > m_prev) ? x - m_prev : m_prev - x;
        if (d == 0 || d >= 2 * int'(max_step_i)) m_run++;
        else m_run = 0;
        if (m_run >= lim) m_abort = 1;
      end
      m_prev = x;
      m_have = 1;
      if (s_last_i && !m_abort) m_done = 1;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit er;
      bit ea;
      bit ed;
      er = m_active && !m_abort && !m_done;
      ea = m_abort;
      ed = m_done;
      checks++;
      if (s_ready_o !== er || abort_o !== ea || done_o !== ed) begin
        errors++;
        $display("FAIL R6 model ready/abort/done act=%b%b%b exp=%b%b%b",
                 s_ready_o, abort_o, done_o, er, ea, ed);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int ms, input int rl);
    @(negedge clk);
    max_step_i = SW'(ms);
    run_len_i  = RW'(rl);
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
  endtask

  task automatic send(input int v, input bit last);
    @(negedge clk);
    s_valid_i = 1'b1;
    s_data_i  = SW'(v);
    s_last_i  = last;
    @(negedge clk);
    s_valid_i = 1'b0;
    s_last_i  = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 abort", abort_o, 1'b0);
    chk("R1 done", done_o, 1'b0);
    chk("R1 ready", s_ready_o, 1'b0);
    rst_n = 1'b1;

    // stuck output: zero steps
    pulse_start(100, 3);
    chk("R2 ready", s_ready_o, 1'b1);
    send(5, 0); send(5, 0); send(5, 0);
    chk("R3 first sample no step", abort_o, 1'b0);
    send(5, 0);
    chk("R4 zero run abort", abort_o, 1'b1);
    chk("R7 ready low", s_ready_o, 1'b0);
    send(500, 1);
    chk("R7 sticky abort", abort_o, 1'b1);
    chk("R7 no done", done_o, 1'b0);

    // threshold boundary and run reset
    pulse_start(100, 2);
    chk("R2 abort cleared", abort_o, 1'b0);
    send(0, 0); send(200, 0); send(399, 0); send(599, 0); send(798, 0);
    chk("R5 199 normal resets run", abort_o, 1'b0);
    send(998, 0);
    chk("R6 one abnormal", abort_o, 1'b0);
    send(1198, 0);
    chk("R5 step 200 abnormal", abort_o, 1'b1);

    // clean ramp with last marker
    pulse_start(100, 2);
    send(0, 0); send(50, 0); send(100, 0); send(150, 1);
    chk("R8 done", done_o, 1'b1);
    chk("R8 no abort", abort_o, 1'b0);
    chk("R8 ready low", s_ready_o, 1'b0);

    // last sample completes the fault
    pulse_start(100, 2);
    send(0, 0); send(0, 0); send(0, 1);
    chk("R8 last abort", abort_o, 1'b1);
    chk("R8 last no done", done_o, 1'b0);

    // run length zero acts as one
    pulse_start(100, 0);
    send(10, 0);
    chk("R10 first alone", abort_o, 1'b0);
    send(10, 0);
    chk("R10 abort on one", abort_o, 1'b1);

    // full-scale swings
    pulse_start(1000, 2);
    send(-2048, 0); send(2047, 0);
    chk("R11 one wide step", abort_o, 1'b0);
    send(-2048, 0);
    chk("R11 wide steps abort", abort_o, 1'b1);

    // clear and idle
    pulse_clear();
    chk("R9 abort", abort_o, 1'b0);
    chk("R9 ready", s_ready_o, 1'b0);
    chk("R9 done", done_o, 1'b0);
    send(7, 1);
    chk("R9 idle ignores", done_o, 1'b0);
    @(negedge clk);
    start_i = 1'b1; clear_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; clear_i = 1'b0;
    chk("R9 clear wins", s_ready_o, 1'b0);

    // restart clears the run
    pulse_start(100, 3);
    send(7, 0); send(7, 0); send(7, 0);
    pulse_start(100, 3);
    send(7, 0); send(7, 0); send(7, 0);
    chk("R2 restart clears run", abort_o, 1'b0);
    send(7, 0);
    chk("R2 run after restart", abort_o, 1'b1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule